// File: doc/BRIEF.md
# Fixed-Frequency PWM Cycle Controller

This block produces the gate-drive pulse train for a voltage-mode switching converter. A digital sawtooth counter sets the switching period. Each period starts with a ramp portion, where the gate may be on. It ends with a discharge portion, where the gate is always off and a clock pulse is reported. The gate turns on at the start of the ramp. It turns off when the ramp reaches a level derived from the control word, or when the current-sense trip bit fires outside the leading-edge blanking window, whichever comes first.

A demagnetisation latch arms when a pulse begins. It releases the first time the gate is off and the zero-crossing comparator bit reads low. While the latch is armed the ramp is held at its valley, so an unfinished demagnetisation stretches the period and the converter runs self-oscillating. When each pulse ends, the block reports whether an overcurrent trip or the PWM comparison terminated it. Mode-control logic uses that report together with the blanking indication.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: While reset is high, `gate_o`, `clk_pulse_o`, `blank_o` and `end_stb_o` are low. With `en_i` high and `ctrl_i` nonzero, the first pulse begins on the first clock edge after reset is released.
- R2: Let PERIOD = CLK_HZ / FSW, where FSW is 40000 (FAST_VARIANT=0) or 75000 (FAST_VARIANT=1). When demagnetisation completes in time, successive gate rising edges are exactly PERIOD clocks apart. Successive `clk_pulse_o` rising edges are also PERIOD clocks apart when no pulses are issued.
- R3: Let RISE = floor(PERIOD*82/100). The pulse lasts thr clocks, where thr = floor(ctrl*RISE / 2^CTRL_W). An all-ones control word gives thr = RISE (maximum duty). A zero control word gives no pulse and no end report.
- R4: `clk_pulse_o` is high for the last PERIOD-RISE clocks of each period, and the gate is low throughout those clocks.
- R5: For the first LEB clocks of a pulse, `blank_o` is high and the trip input is ignored. LEB = floor(LEB_NS*(CLK_HZ/10^6)/1000), where LEB_NS is 480 for the slow variant and 250 for the fast variant.
- R6: If the trip input is high in on-clock k (counted from 0) with k >= LEB, the pulse ends after k+1 clocks.
- R7: In the first clock the gate is low after a pulse, `end_stb_o` is high for exactly one clock. In the same clock `end_oc_o` is 1 for a trip end and 0 for a PWM end. When both happen together, the trip wins.
- R8: The demag latch arms when a pulse starts and releases at the end of the first clock j (counted from the pulse start) in which the gate is low and `zcd_i` is low. No pulse starts while the latch is armed, so the period becomes max(PERIOD, j+2).
- R9: Once the latch has released, `zcd_i` going high again (ringing) does not re-arm it or delay the next pulse.
- R10: With `en_i` low, `gate_o` is low in the same clock. From the next edge the ramp sits at its valley (`clk_pulse_o` low), the latch is released and no end report is produced. After re-enable the next pulse starts on the first edge, whatever the state of `zcd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| ctrl_i | input | CTRL_W | Control word from the regulation loop |
| cs_trip_i | input | 1 | Current-sense comparator bit (1 = over threshold) |
| zcd_i | input | 1 | Demag comparator bit (1 = winding above threshold) |
| gate_o | output | 1 | Gate drive |
| clk_pulse_o | output | 1 | High during the ramp discharge portion |
| blank_o | output | 1 | Leading-edge blanking active |
| end_stb_o | output | 1 | One-clock strobe when a pulse ends |
| end_oc_o | output | 1 | Cause of the last pulse end (1 = overcurrent) |

## Verification
The gate rises on the edge after the start condition. An input sampled in on-clock k acts on the edge that closes that clock, so a trip there yields width k+1. The end strobe and its cause appear in the same sample in which the gate is first seen low. Disabling removes the gate in the same clock with no edge in between, while the ramp and latch state settle on the next edge. The bench samples all outputs and drives all inputs 1 ns after each rising edge. It counts clock by clock from the observed gate rising edge, so every width, period and strobe is compared against the cycle index predicted by these latencies.

// File: rtl/pwm_cyc_pkg.sv
package pwm_cyc_pkg;

  // Sawtooth portions of one switching period
  typedef enum logic [1:0] {
    PH_VALLEY = 2'd0,  // held at valley, waiting for demag release
    PH_RAMP   = 2'd1,  // charging portion, gate may be on
    PH_DISCH  = 2'd2   // discharge portion, clock pulse reported
  } ramp_ph_e;

  // Convert a duration in ns to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int clk_hz);
    return (ns * (clk_hz / 1000000)) / 1000;
  endfunction

endpackage

// File: rtl/pwm_level_map.sv
// Maps the control word onto a ramp count threshold.
module pwm_level_map #(
  parameter int CTRL_W = 10,
  parameter int RISE   = 5125,
  parameter int CNT_W  = 13
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [CNT_W-1:0]  thr_o
);
  localparam int PROD_W = CTRL_W + CNT_W;
  localparam logic [CTRL_W-1:0] FULL = {CTRL_W{1'b1}};

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(ctrl_i) * PROD_W'(RISE);
    if (ctrl_i == FULL) thr_o = CNT_W'(RISE);
    else                thr_o = CNT_W'(prod >> CTRL_W);
  end
endmodule

// File: rtl/pwm_ramp_gen.sv
// Digital sawtooth: ramp, discharge, optional valley wait.
module pwm_ramp_gen
  import pwm_cyc_pkg::*;
#(
  parameter int RISE  = 5125,
  parameter int FALL  = 1125,
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             pend_i,
  output ramp_ph_e         ph_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(RISE - 1);
  localparam logic [CNT_W-1:0] FALL_LAST = CNT_W'(FALL - 1);

  ramp_ph_e         ph_q;
  logic [CNT_W-1:0] cnt_q;

  // A new period may begin from the valley, or straight from the last
  // discharge count when demag has already been released.
  always_comb begin
    start_o = en_i && !pend_i &&
              ((ph_q == PH_VALLEY) ||
               (ph_q == PH_DISCH && cnt_q == FALL_LAST));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      ph_q  <= PH_VALLEY;
      cnt_q <= '0;
    end else if (start_o) begin
      ph_q  <= PH_RAMP;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_RAMP: begin
          if (cnt_q == RISE_LAST) begin
            ph_q  <= PH_DISCH;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_DISCH: begin
          if (cnt_q == FALL_LAST) begin
            ph_q  <= PH_VALLEY;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          ph_q  <= PH_VALLEY;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign ph_o  = ph_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_leb.sv
// Leading-edge blanking window timer.
module pwm_leb #(
  parameter int LEB = 120
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic gate_set_i,
  input  logic gate_q_i,
  output logic blank_o
);
  localparam int LW = $clog2(LEB + 2);
  localparam logic [LW-1:0] LIM = LW'(LEB);

  logic [LW-1:0] age_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      age_q <= LIM;
    end else if (gate_set_i) begin
      age_q <= '0;
    end else if (gate_q_i && age_q < LIM) begin
      age_q <= age_q + LW'(1);
    end
  end

  assign blank_o = gate_q_i && (age_q < LIM);
endmodule

// File: rtl/pwm_demag_latch.sv
// Demagnetisation pending flag: armed by a pulse start, released once the
// winding is seen below threshold with the gate off; ringing is ignored.
module pwm_demag_latch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic gate_set_i,
  input  logic gate_q_i,
  input  logic zcd_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      pend_q <= 1'b0;
    end else if (gate_set_i) begin
      pend_q <= 1'b1;
    end else if (!gate_q_i && !zcd_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pwm_gate_latch.sv
// PWM latch: set at period start, reset by ramp crossing or trip.
module pwm_gate_latch
  import pwm_cyc_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] thr_i,
  input  ramp_ph_e         ph_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cs_trip_i,
  input  logic             blank_i,
  output logic             gate_q_o,
  output logic             set_o,
  output logic             end_stb_o,
  output logic             end_oc_o
);
  logic gate_q, stb_q, oc_q;
  logic pwm_end, trip_end;

  always_comb begin
    set_o    = start_i && (thr_i != '0);
    trip_end = gate_q && cs_trip_i && !blank_i;
    pwm_end  = gate_q && ((ph_i != PH_RAMP) ||
               (({1'b0, cnt_i} + (CNT_W+1)'(1)) >= {1'b0, thr_i}));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q <= 1'b0;
      stb_q  <= 1'b0;
      oc_q   <= 1'b0;
    end else if (!en_i) begin
      gate_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (set_o) begin
        gate_q <= 1'b1;
      end else if (trip_end || pwm_end) begin
        gate_q <= 1'b0;
        stb_q  <= 1'b1;
        oc_q   <= trip_end;
      end
    end
  end

  assign gate_q_o  = gate_q;
  assign end_stb_o = stb_q;
  assign end_oc_o  = oc_q;
endmodule

// File: rtl/pwm_cycle_ctrl.sv
// Top: fixed-frequency PWM cycle controller.
module pwm_cycle_ctrl
  import pwm_cyc_pkg::*;
#(
  parameter int CLK_HZ       = 250_000_000,
  parameter bit FAST_VARIANT = 1'b0,
  parameter int CTRL_W       = 10,
  parameter int DMAX_PCT     = 82
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cs_trip_i,
  input  logic              zcd_i,
  output logic              gate_o,
  output logic              clk_pulse_o,
  output logic              blank_o,
  output logic              end_stb_o,
  output logic              end_oc_o
);
  localparam int FSW    = FAST_VARIANT ? 75000 : 40000;
  localparam int LEB_NS = FAST_VARIANT ? 250 : 480;
  localparam int PERIOD = CLK_HZ / FSW;
  localparam int RISE   = (PERIOD * DMAX_PCT) / 100;
  localparam int FALL   = PERIOD - RISE;
  localparam int LEB    = ns_to_cyc(LEB_NS, CLK_HZ);
  localparam int CNT_W  = $clog2(PERIOD + 1);

  ramp_ph_e         ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;
  logic             start, gate_set, gate_q, dmg_pend, blank;

  pwm_level_map #(.CTRL_W(CTRL_W), .RISE(RISE), .CNT_W(CNT_W)) u_map (
    .ctrl_i (ctrl_i),
    .thr_o  (thr)
  );

  pwm_ramp_gen #(.RISE(RISE), .FALL(FALL), .CNT_W(CNT_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .pend_i  (dmg_pend),
    .ph_o    (ph),
    .cnt_o   (cnt),
    .start_o (start)
  );

  pwm_leb #(.LEB(LEB)) u_leb (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .gate_set_i (gate_set),
    .gate_q_i   (gate_q),
    .blank_o    (blank)
  );

  pwm_demag_latch u_dmg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .en_i       (en_i),
    .gate_set_i (gate_set),
    .gate_q_i   (gate_q),
    .zcd_i      (zcd_i),
    .pend_o     (dmg_pend)
  );

  pwm_gate_latch #(.CNT_W(CNT_W)) u_gate (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .en_i      (en_i),
    .start_i   (start),
    .thr_i     (thr),
    .ph_i      (ph),
    .cnt_i     (cnt),
    .cs_trip_i (cs_trip_i),
    .blank_i   (blank),
    .gate_q_o  (gate_q),
    .set_o     (gate_set),
    .end_stb_o (end_stb_o),
    .end_oc_o  (end_oc_o)
  );

  // Disable removes the drive within the same clock
  assign gate_o      = gate_q & en_i;
  assign clk_pulse_o = (ph == PH_DISCH);
  assign blank_o     = blank;
endmodule

// File: rtl/pwm_cycle_ctrl_chk.sv
module pwm_cycle_ctrl_chk (
  input logic clk_i,
  input logic rst_i,
  input logic en_i,
  input logic cs_trip_i,
  input logic gate_o,
  input logic clk_pulse_o,
  input logic blank_o,
  input logic end_stb_o,
  input logic end_oc_o,
  input logic gate_q,
  input logic pend
);
  // Allows one gate start per discharge interval (or after disable/reset)
  logic armed;
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i || clk_pulse_o) armed <= 1'b1;
    else if (gate_q)                   armed <= 1'b0;
  end

  a_r4_no_gate_in_discharge: assert property (@(posedge clk_i) disable iff (rst_i)
    !(gate_o && clk_pulse_o));

  a_r3_one_pulse_per_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(gate_q) |-> armed);

  a_r10_disable_gate_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |-> !gate_o);

  a_r7_oc_cause: assert property (@(posedge clk_i) disable iff (rst_i)
    (end_stb_o && end_oc_o) |-> ($past(cs_trip_i) && !$past(blank_o)));

  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
    end_stb_o |=> !end_stb_o);

  a_r8_pending_blocks_start: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(gate_q) |-> !$past(pend));

  a_r5_blank_only_on: assert property (@(posedge clk_i) disable iff (rst_i)
    blank_o |-> gate_q);
endmodule

bind pwm_cycle_ctrl pwm_cycle_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .en_i        (en_i),
  .cs_trip_i   (cs_trip_i),
  .gate_o      (gate_o),
  .clk_pulse_o (clk_pulse_o),
  .blank_o     (blank_o),
  .end_stb_o   (end_stb_o),
  .end_oc_o    (end_oc_o),
  .gate_q      (gate_q),
  .pend        (dmg_pend)
);

// File: tb/test_pwm_cycle_ctrl.sv
`timescale 1ns/1ps
module test_pwm_cycle_ctrl;
  localparam int CLK_HZ = 25_000_000;
  localparam int CW     = 10;
  localparam int PER    = CLK_HZ / 40000;          // 625
  localparam int RISE   = (PER * 82) / 100;        // 512
  localparam int FALL   = PER - RISE;              // 113
  localparam int LEB    = (480 * (CLK_HZ / 1000000)) / 1000; // 12

  logic clk = 1'b0;
  logic rst, en, cs_trip, zcd;
  logic [CW-1:0] ctrl;
  logic gate_o, clk_pulse_o, blank_o, end_stb_o, end_oc_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_cycle_ctrl #(.CLK_HZ(CLK_HZ), .FAST_VARIANT(1'b0), .CTRL_W(CW)) i_pwm_cycle_ctrl (
    .clk_i(clk), .rst_i(rst), .en_i(en), .ctrl_i(ctrl), .cs_trip_i(cs_trip),
    .zcd_i(zcd), .gate_o(gate_o), .clk_pulse_o(clk_pulse_o), .blank_o(blank_o),
    .end_stb_o(end_stb_o), .end_oc_o(end_oc_o));

  function automatic int f_thr(input int c);
    if (c == (1 << CW) - 1) return RISE;
    return (c * RISE) >> CW;
  endfunction

  function automatic int f_period(input int w, input int hi);
    int j0 = (w > hi) ? w : hi;
    return (j0 + 2 > PER) ? j0 + 2 : PER;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_rise(output int waited);
    bit prev = gate_o;
    waited = -1;
    for (int i = 1; i <= 4 * PER; i++) begin
      tick();
      if (gate_o && !prev) begin waited = i; break; end
      prev = gate_o;
    end
  endtask

  // Starts in the clock where the gate has just been seen rising.
  task automatic run_period(input int trip_at, input int hi_len, input int ring_at,
                            input int ring_len, output int width, output int period,
                            output bit oc, output int stb_cnt, output int clk_cnt,
                            output int blank_err);
    bit fell = 1'b0;
    width = -1; period = -1; oc = 1'b0; stb_cnt = 0; clk_cnt = 0; blank_err = 0;
    for (int j = 0; j < 6 * PER; j++) begin
      if (gate_o) begin
        if (blank_o != (j < LEB)) blank_err++;
      end else if (blank_o) blank_err++;
      if (clk_pulse_o) clk_cnt++;
      if (end_stb_o) begin stb_cnt++; oc = end_oc_o; end
      cs_trip = (j == trip_at);
      zcd = (j < hi_len) || (j >= ring_at && j < ring_at + ring_len);
      tick();
      if (!gate_o && !fell) begin fell = 1'b1; width = j + 1; end
      if (gate_o && fell) begin period = j + 1; break; end
    end
    cs_trip = 1'b0;
    zcd = 1'b0;
  endtask

  // Measure one period and check everything against expectations
  task automatic measure(input string tag, input int trip_at, input int hi_len,
                         input int ring_at, input int ring_len, input int exp_w,
                         input bit exp_oc, input int exp_per);
    int w, p, s, c, b;
    bit oc;
    run_period(trip_at, hi_len, ring_at, ring_len, w, p, oc, s, c, b);
    chk(w == exp_w, {tag, " width"}, w, exp_w);
    chk(p == exp_per, {tag, " period"}, p, exp_per);
    chk(s == 1, "R7 end strobe count", s, 1);
    chk(oc == exp_oc, {"R7 end cause ", tag}, oc, exp_oc);
    chk(c == FALL, "R4 clock pulse length", c, FALL);
    chk(b == 0, "R5 blank window", b, 0);
  endtask

  task automatic skip_period();
    int w, p, s, c, b;
    bit oc;
    run_period(-1, 0, 0, 0, w, p, oc, s, c, b);
  endtask

  initial begin
    int wt, k, g_hi, s_hi, r1, r2, rises;
    bit prev_c;
    void'($urandom(32'd1234));
    rst = 1'b1; en = 1'b1; ctrl = CW'(600); cs_trip = 1'b0; zcd = 1'b0;
    repeat (3) tick();
    chk(!gate_o && !clk_pulse_o && !blank_o && !end_stb_o, "R1 reset outputs",
        {gate_o, clk_pulse_o, blank_o, end_stb_o}, 0);
    rst = 1'b0;
    tick();
    chk(gate_o == 1'b1, "R1 first pulse after reset", gate_o, 1);

    // R2 R3 nominal pulse
    measure("R3 ctrl600", -1, 0, 0, 0, f_thr(600), 1'b0, PER);

    // R3 random control words
    for (int i = 0; i < 6; i++) begin
      int c = 64 + int'($urandom % 900);
      ctrl = CW'(c);
      skip_period();
      measure("R3 random", -1, 0, 0, 0, f_thr(c), 1'b0, PER);
    end

    // R3 full scale gives maximum duty
    ctrl = '1;
    skip_period();
    measure("R3 full scale", -1, 0, 0, 0, RISE, 1'b0, PER);

    // Trip handling at thr = 400
    ctrl = CW'(800);
    skip_period();
    measure("R5 trip in blanking", LEB - 1, 0, 0, 0, f_thr(800), 1'b0, PER);
    measure("R6 trip at blank end", LEB, 0, 0, 0, LEB + 1, 1'b1, PER);
    k = LEB + 1 + int'($urandom % (f_thr(800) - LEB - 3));
    measure("R6 trip random", k, 0, 0, 0, k + 1, 1'b1, PER);
    measure("R7 trip and pwm tie", f_thr(800) - 1, 0, 0, 0, f_thr(800), 1'b1, PER);

    // Demag handling
    measure("R8 demag in time", -1, 450, 0, 0, f_thr(800), 1'b0, f_period(400, 450));
    measure("R8 demag late", -1, PER + 20, 0, 0, f_thr(800), 1'b0,
            f_period(400, PER + 20));
    measure("R9 ringing ignored", -1, 420, 430, 30, f_thr(800), 1'b0, PER);

    // R10 disable mid-pulse with demag still pending
    zcd = 1'b1;
    repeat (5) tick();
    en = 1'b0;
    #0.5;
    chk(gate_o == 1'b0, "R10 gate low same clock", gate_o, 0);
    tick();
    chk(!gate_o && !clk_pulse_o && !end_stb_o, "R10 idle after disable",
        {gate_o, clk_pulse_o, end_stb_o}, 0);
    repeat (3) tick();
    en = 1'b1;
    tick();
    chk(gate_o == 1'b1, "R10 restart ignores pending demag", gate_o, 1);
    zcd = 1'b0;
    measure("R10 after restart", -1, 0, 0, 0, f_thr(800), 1'b0, PER);

    // R3 zero control word: no pulses, R2 clock period kept
    ctrl = '0;
    repeat (2) tick();
    g_hi = 0; s_hi = 0; r1 = -1; r2 = -1; rises = 0; prev_c = clk_pulse_o;
    for (int i = 0; i < 3 * PER; i++) begin
      tick();
      if (gate_o) g_hi++;
      if (end_stb_o) s_hi++;
      if (clk_pulse_o && !prev_c) begin
        rises++;
        if (rises == 1) r1 = i;
        if (rises == 2) r2 = i;
      end
      prev_c = clk_pulse_o;
    end
    chk(g_hi == 0, "R3 zero word no pulse", g_hi, 0);
    chk(s_hi == 0, "R3 zero word no report", s_hi, 0);
    chk(r2 - r1 == PER, "R2 clock period without pulses", r2 - r1, PER);

    // Resume operation
    ctrl = CW'(600);
    wait_rise(wt);
    chk(wt > 0, "R2 resume after zero word", wt, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule